// File: doc/BRIEF.md
# DSP reset and boot-load sequencer

This block brings a small DSP core out of reset and holds program execution until the start-up path chosen by the mode pins has finished. It keeps a core-clear line high during reset. That line empties the stacks, masks every interrupt and zeroes the mode/status register. The first reset after power-on is held for a PLL lock interval. Any later reset only has to last a short minimum time.

While reset is low, a two-bit boot mode is taken from the mode pins. After release the latched value ignores the pins, because one of them is also used as a general-purpose flag. Three start-up paths follow:
- A byte-memory DMA boot copies the first 32 program words into program memory.
- A host boot waits until the host writes program address 0.
- A no-boot start runs at once from external address 0.

A pending bus request at release postpones all three paths until the request is withdrawn.

Top module: `boot_seq`

## Requirements
- R1: After power-on (`por_n` released), `core_clr` stays high for exactly PLL_WAIT (default 2000) clock cycles, even if `rst_n` goes high earlier.
- R2: A reset after the first release drops `core_clr` on the first clock edge where `rst_n` is high and at least MIN_RST (default 4) cycles have passed in reset. No PLL wait applies.
- R3: During reset, `core_clr` is 1 and `core_run` and `boot_done` are 0. Reset has priority over every other input.
- R4: `boot_mode` follows `mode_pins` only on clock edges where `rst_n` is low, and holds its value otherwise. Encoding: 00 selects DMA boot, 01 selects no boot, 10 and 11 select host boot.
- R5: In DMA boot, byte addresses 0 to 95 are read with one-cycle read latency. Each group of three bytes forms one 24-bit word, most significant byte first. The words are written to program addresses 0 to 31 in order, one write at a time.
- R6: In DMA boot, `core_run` and `boot_done` rise one cycle after the write to program address 31.
- R7: In host boot, no byte reads or program writes are issued. `core_run` and `boot_done` rise one cycle after a cycle with `host_we`=1 and `host_addr`=0. Host writes to other addresses have no effect.
- R8: In no-boot mode, `core_run` rises one cycle after reset release. `fetch_ext`=1 and `boot_done` stays 0.
- R9: If `bus_req` is high at release, there are no reads, no writes, no host response and no `core_run` until `bus_req` is low.
- R10: In the boot modes `fetch_ext`=0, so the core fetches from on-chip address 0. After rising, `core_run` and `boot_done` stay high until the next reset, whatever `bus_req` and `host_we` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Master reset request, active low, synchronous |
| mode_pins | input | 2 | Boot mode select pins |
| bus_req | input | 1 | External bus request |
| host_we | input | 1 | Observed host write strobe to program memory |
| host_addr | input | PADDR_W | Program address of the observed host write |
| bm_rd_en | output | 1 | Byte-memory read enable |
| bm_addr | output | BADDR_W | Byte-memory read address |
| bm_rdata | input | BYTE_W | Byte-memory read data, valid one cycle after the read |
| pm_we | output | 1 | Program-memory write enable |
| pm_addr | output | PADDR_W | Program-memory write address |
| pm_wdata | output | WORD_W | Program-memory write data |
| core_clr | output | 1 | Core held in reset: empty stacks, mask interrupts, clear status |
| core_run | output | 1 | Program execution enable |
| boot_done | output | 1 | A boot load has completed since the last reset |
| fetch_ext | output | 1 | 1: first fetch from external address 0; 0: from on-chip address 0 |
| boot_mode | output | 2 | Latched boot mode |

## Verification
The bench targets these cases:
- **Cold-start hold.** `rst_n` is released early. A design that honoured that release would start the core before PLL_WAIT cycles.
- **Pin changes after release.** A design that failed to latch the mode would switch path partway through the boot.
- **Warm reset in the middle of a DMA load.** A design that kept its counters would write the wrong words or finish early.
- **Host writes to the wrong address, and host writes made while a bus request is pending.** A design that ignored the address or the request would start the core too soon.
- **Timing of `core_run`.** Off-by-one release timing would show up as `core_run` rising in the same cycle as the final write, or two cycles after it.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD = 3'd0,
        ST_BUSW = 3'd1,
        ST_DMA  = 3'd2,
        ST_HOST = 3'd3,
        ST_RUN  = 3'd4
    } seq_state_e;

    localparam logic [1:0] MODE_DMA  = 2'b00;
    localparam logic [1:0] MODE_NONE = 2'b01;

endpackage

// File: rtl/boot_rst_ctrl.sv
// Reset hold timing and boot-mode latch.
module boot_rst_ctrl #(
    parameter int PLL_WAIT = 2000,
    parameter int MIN_RST  = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic [1:0] mode_pins,
    output logic       in_rst,
    output logic       release_go,
    output logic [1:0] boot_mode
);
    localparam int CNT_W = $clog2(PLL_WAIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PLL_WAIT);
    localparam logic [CNT_W-1:0] COLD_LIM = CNT_W'(PLL_WAIT - 1);
    localparam logic [CNT_W-1:0] WARM_LIM = CNT_W'(MIN_RST - 1);

    typedef struct packed {
        logic             in_rst;
        logic             warm;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       mode;
    } rst_regs_t;

    rst_regs_t q, d;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] lim;
    logic             go;

    always_comb begin
        cnt_inc = (q.cnt == CNT_MAX) ? q.cnt : q.cnt + 1'b1;
        lim     = q.warm ? WARM_LIM : COLD_LIM;
        go      = q.in_rst && rst_n && (q.cnt >= lim);
        d       = q;
        if (!rst_n) begin
            d.in_rst = 1'b1;
            d.mode   = mode_pins;
            d.cnt    = q.in_rst ? cnt_inc : '0;
        end else if (q.in_rst) begin
            if (go) begin
                d.in_rst = 1'b0;
                d.warm   = 1'b1;
                d.cnt    = '0;
            end else begin
                d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.in_rst <= 1'b1;
            q.warm   <= 1'b0;
            q.cnt    <= '0;
            q.mode   <= 2'b00;
        end else begin
            q <= d;
        end
    end

    assign in_rst     = q.in_rst;
    assign release_go = go;
    assign boot_mode  = q.mode;

    p_clr_on_reset_r3: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> in_rst);

    p_mode_frozen_r4: assert property (@(posedge clk) disable iff (!por_n)
        rst_n |=> $stable(boot_mode));

    p_release_needs_high_r2: assert property (@(posedge clk) disable iff (!por_n)
        $fell(in_rst) |-> $past(rst_n));

endmodule

// File: rtl/boot_dma_eng.sv
// Byte-to-word boot copy engine.
module boot_dma_eng #(
    parameter int BOOT_WORDS = 32,
    parameter int WORD_W     = 24,
    parameter int BYTE_W     = 8,
    parameter int BADDR_W    = 16,
    parameter int PADDR_W    = 14
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               active,
    output logic               bm_rd_en,
    output logic [BADDR_W-1:0] bm_addr,
    input  logic [BYTE_W-1:0]  bm_rdata,
    output logic               pm_we,
    output logic [PADDR_W-1:0] pm_addr,
    output logic [WORD_W-1:0]  pm_wdata,
    output logic               last_wr
);
    localparam int BPW    = WORD_W / BYTE_W;
    localparam int NBYTES = BOOT_WORDS * BPW;
    localparam int IDX_W  = $clog2(NBYTES + 1);
    localparam int SUB_W  = (BPW > 1) ? $clog2(BPW) : 1;
    localparam int WRD_W  = $clog2(BOOT_WORDS);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(NBYTES);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BPW - 1);
    localparam logic [WRD_W-1:0] WRD_LAST = WRD_W'(BOOT_WORDS - 1);

    typedef struct packed {
        logic [IDX_W-1:0]  rd_idx;
        logic              vld;
        logic [SUB_W-1:0]  sub;
        logic [WORD_W-1:0] acc;
        logic [WRD_W-1:0]  wr_idx;
        logic              we;
        logic [WRD_W-1:0]  waddr;
        logic [WORD_W-1:0] wdata;
    } dma_regs_t;

    dma_regs_t q, d;
    logic              issue;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        issue   = active && (q.rd_idx < IDX_END);
        shifted = {q.acc[WORD_W-BYTE_W-1:0], bm_rdata};
        d       = q;
        d.vld   = 1'b0;
        d.we    = 1'b0;
        if (!active) begin
            d = '0;
        end else begin
            if (issue) begin
                d.rd_idx = q.rd_idx + 1'b1;
                d.vld    = 1'b1;
            end
            if (q.vld) begin
                d.acc = shifted;
                if (q.sub == SUB_LAST) begin
                    d.sub    = '0;
                    d.we     = 1'b1;
                    d.waddr  = q.wr_idx;
                    d.wdata  = shifted;
                    d.wr_idx = q.wr_idx + 1'b1;
                end else begin
                    d.sub = q.sub + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bm_rd_en = issue;
    assign bm_addr  = BADDR_W'(q.rd_idx);
    assign pm_we    = q.we;
    assign pm_addr  = PADDR_W'(q.waddr);
    assign pm_wdata = q.wdata;
    assign last_wr  = q.we && (q.waddr == WRD_LAST);

    p_write_spacing_r5: assert property (@(posedge clk) disable iff (!por_n)
        pm_we |=> !pm_we);

    p_read_addr_step_r5: assert property (@(posedge clk) disable iff (!por_n)
        (bm_rd_en && $past(bm_rd_en)) |-> (bm_addr == $past(bm_addr) + 1'b1));

endmodule

// File: rtl/boot_seq.sv
// Reset and boot-load sequencer top.
module boot_seq
    import boot_seq_pkg::*;
#(
    parameter int PLL_WAIT   = 2000,
    parameter int MIN_RST    = 4,
    parameter int BOOT_WORDS = 32,
    parameter int WORD_W     = 24,
    parameter int BYTE_W     = 8,
    parameter int BADDR_W    = 16,
    parameter int PADDR_W    = 14
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic [1:0]         mode_pins,
    input  logic               bus_req,
    input  logic               host_we,
    input  logic [PADDR_W-1:0] host_addr,
    output logic               bm_rd_en,
    output logic [BADDR_W-1:0] bm_addr,
    input  logic [BYTE_W-1:0]  bm_rdata,
    output logic               pm_we,
    output logic [PADDR_W-1:0] pm_addr,
    output logic [WORD_W-1:0]  pm_wdata,
    output logic               core_clr,
    output logic               core_run,
    output logic               boot_done,
    output logic               fetch_ext,
    output logic [1:0]         boot_mode
);
    typedef struct packed {
        seq_state_e state;
        logic       run;
        logic       done;
    } top_regs_t;

    top_regs_t q, d;
    logic      in_rst;
    logic      go;
    logic      dma_active;
    logic      dma_last;
    logic [1:0] mode;

    boot_rst_ctrl #(
        .PLL_WAIT(PLL_WAIT),
        .MIN_RST (MIN_RST)
    ) u_rst (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .mode_pins (mode_pins),
        .in_rst    (in_rst),
        .release_go(go),
        .boot_mode (mode)
    );

    assign dma_active = (q.state == ST_DMA) && rst_n;

    boot_dma_eng #(
        .BOOT_WORDS(BOOT_WORDS),
        .WORD_W    (WORD_W),
        .BYTE_W    (BYTE_W),
        .BADDR_W   (BADDR_W),
        .PADDR_W   (PADDR_W)
    ) u_dma (
        .clk     (clk),
        .por_n   (por_n),
        .active  (dma_active),
        .bm_rd_en(bm_rd_en),
        .bm_addr (bm_addr),
        .bm_rdata(bm_rdata),
        .pm_we   (pm_we),
        .pm_addr (pm_addr),
        .pm_wdata(pm_wdata),
        .last_wr (dma_last)
    );

    always_comb begin
        d = q;
        if (!rst_n) begin
            d.state = ST_HOLD;
            d.run   = 1'b0;
            d.done  = 1'b0;
        end else begin
            unique case (q.state)
                ST_HOLD: begin
                    if (go) begin
                        if (bus_req)                d.state = ST_BUSW;
                        else if (mode == MODE_NONE) begin d.state = ST_RUN; d.run = 1'b1; end
                        else if (mode == MODE_DMA)  d.state = ST_DMA;
                        else                        d.state = ST_HOST;
                    end
                end
                ST_BUSW: begin
                    if (!bus_req) begin
                        if (mode == MODE_NONE)     begin d.state = ST_RUN; d.run = 1'b1; end
                        else if (mode == MODE_DMA) d.state = ST_DMA;
                        else                       d.state = ST_HOST;
                    end
                end
                ST_DMA: begin
                    if (dma_last) begin
                        d.state = ST_RUN;
                        d.run   = 1'b1;
                        d.done  = 1'b1;
                    end
                end
                ST_HOST: begin
                    if (host_we && (host_addr == '0)) begin
                        d.state = ST_RUN;
                        d.run   = 1'b1;
                        d.done  = 1'b1;
                    end
                end
                ST_RUN:  d.state = ST_RUN;
                default: d.state = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.state <= ST_HOLD;
            q.run   <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign core_clr  = in_rst;
    assign core_run  = q.run;
    assign boot_done = q.done;
    assign fetch_ext = (mode == MODE_NONE);
    assign boot_mode = mode;

    p_run_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
        (core_run && rst_n) |=> core_run);

    p_host_quiet_r7: assert property (@(posedge clk) disable iff (!por_n)
        (q.state == ST_HOST) |-> (!bm_rd_en && !pm_we));

    p_bus_defer_r9: assert property (@(posedge clk) disable iff (!por_n)
        (q.state == ST_BUSW && bus_req && rst_n) |=> (q.state == ST_BUSW && !core_run));

    p_no_run_in_reset_r3: assert property (@(posedge clk) disable iff (!por_n)
        core_clr |-> (!core_run && !boot_done));

endmodule

// File: tb/tb_boot_seq.sv
module tb_boot_seq;
    localparam int PLL = 2000;
    localparam int MINR = 4;
    localparam int BW = 32;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_pins = 2'b00;
    logic        bus_req = 1'b0;
    logic        host_we = 1'b0;
    logic [13:0] host_addr = '0;
    logic        bm_rd_en;
    logic [15:0] bm_addr;
    logic [7:0]  bm_rdata = '0;
    logic        pm_we;
    logic [13:0] pm_addr;
    logic [23:0] pm_wdata;
    logic        core_clr, core_run, boot_done, fetch_ext;
    logic [1:0]  boot_mode;

    int checks = 0;
    int fails = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    boot_seq dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .mode_pins(mode_pins),
        .bus_req(bus_req), .host_we(host_we), .host_addr(host_addr),
        .bm_rd_en(bm_rd_en), .bm_addr(bm_addr), .bm_rdata(bm_rdata),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .core_clr(core_clr), .core_run(core_run), .boot_done(boot_done),
        .fetch_ext(fetch_ext), .boot_mode(boot_mode)
    );

    function automatic logic [7:0] bval(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [23:0] wexp(input int j);
        return {bval(3 * j), bval(3 * j + 1), bval(3 * j + 2)};
    endfunction

    always @(posedge clk) if (bm_rd_en) bm_rdata <= bval(int'(bm_addr));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: 0 reset, 1 bus wait, 2 dma, 3 host, 4 running
    int   ph = 0, cnt = 0, nwr = 0;
    bit   warm = 0, run = 0, done = 0, pmw_s = 0;
    logic [1:0] mm = 2'b00;

    task automatic dispatch();
        if (mm == 2'b01) begin ph = 4; run = 1; end
        else if (mm == 2'b00) begin ph = 2; nwr = 0; end
        else ph = 3;
    endtask

    always @(posedge clk) if (por_n) begin
        bit pmw;
        pmw = pmw_s;
        pmw_s = 0;
        if (!rst_n) begin
            if (ph != 0) cnt = 0;
            else if (cnt < PLL) cnt++;
            ph = 0; mm = mode_pins; run = 0; done = 0;
        end else begin
            case (ph)
                0: if (cnt >= (warm ? MINR : PLL) - 1) begin
                       warm = 1; cnt = 0;
                       if (bus_req) ph = 1; else dispatch();
                   end else if (cnt < PLL) cnt++;
                1: if (!bus_req) dispatch();
                2: if (pmw && nwr == BW) begin ph = 4; run = 1; done = 1; end
                3: if (host_we && host_addr == 0) begin ph = 4; run = 1; done = 1; end
                default: ;
            endcase
        end
    end

    always @(negedge clk) if (por_n && !ended) begin
        chk(core_clr == (ph == 0), warm ? "R2" : "R1", "core_clr", core_clr, ph == 0);
        chk(core_run == run, (mm == 2'b01) ? "R8" : (mm == 2'b00) ? "R6" : "R7",
            "core_run", core_run, run);
        chk(boot_done == done, "R10", "boot_done", boot_done, done);
        chk(fetch_ext == (mm == 2'b01), "R8", "fetch_ext", fetch_ext, mm == 2'b01);
        chk(boot_mode == mm, "R4", "boot_mode", boot_mode, mm);
        if (ph == 0) chk(!core_run && !boot_done, "R3", "run/done in reset", core_run, 0);
        if (ph != 2) chk(!bm_rd_en && !pm_we, (ph == 1) ? "R9" : "R7",
                         "memory activity", {bm_rd_en, pm_we}, 0);
        if (pm_we) begin
            chk(pm_addr == 14'(nwr), "R5", "pm_addr", pm_addr, nwr);
            chk(pm_wdata == wexp(nwr), "R5", "pm_wdata", pm_wdata, wexp(nwr));
            nwr++;
            pmw_s = 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset state before power-on release (R3)
        step(3);
        chk(core_clr == 1 && core_run == 0 && boot_done == 0, "R3", "por state",
            {core_clr, core_run, boot_done}, 3'b100);
        por_n = 1;
        // Cold start, DMA mode, rst_n released early (R1); pins change after (R4)
        step(10);
        rst_n = 1;
        step(2);
        mode_pins = 2'b11;
        for (int i = 0; i < 2300 && !core_run; i++) step(1);
        step(2);
        chk(nwr == BW, "R5", "word count", nwr, BW);
        chk(boot_done && !fetch_ext, "R10", "dma done, on-chip fetch", {boot_done, fetch_ext}, 2'b10);
        chk(boot_mode == 2'b00, "R4", "mode after pin change", boot_mode, 0);

        // Warm short reset, no boot (R2, R8)
        rst_n = 0; mode_pins = 2'b01;
        step(1);
        rst_n = 1; mode_pins = 2'b00;
        step(10);
        chk(core_run && fetch_ext && !boot_done, "R8", "no-boot run",
            {core_run, fetch_ext, boot_done}, 3'b110);

        // Host boot, mode 10 (R7)
        rst_n = 0; mode_pins = 2'b10;
        step(6);
        rst_n = 1;
        step(10);
        host_we = 1; host_addr = 14'd5;
        step(1);
        host_we = 0;
        step(5);
        chk(!core_run, "R7", "write to addr 5 ignored", core_run, 0);
        host_we = 1; host_addr = 14'd0;
        step(1);
        host_we = 0;
        step(3);
        chk(core_run && boot_done, "R7", "host boot done", {core_run, boot_done}, 3);

        // Host boot mode 11 with bus request at release (R9)
        rst_n = 0; mode_pins = 2'b11; bus_req = 1;
        step(2);
        rst_n = 1;
        step(20);
        host_we = 1; host_addr = 14'd0;
        step(1);
        host_we = 0;
        step(3);
        chk(!core_run, "R9", "host write during bus request", core_run, 0);
        bus_req = 0;
        step(3);
        host_we = 1;
        step(1);
        host_we = 0;
        step(3);
        chk(core_run, "R7", "mode 11 host boot", core_run, 1);

        // DMA with bus request, then warm reset mid-load (R9, R5, R6)
        rst_n = 0; mode_pins = 2'b00; bus_req = 1;
        step(5);
        rst_n = 1;
        step(15);
        chk(!bm_rd_en && !core_run, "R9", "dma deferred", {bm_rd_en, core_run}, 0);
        bus_req = 0;
        step(50);
        rst_n = 0;
        step(4);
        rst_n = 1;
        for (int i = 0; i < 300 && !core_run; i++) step(1);
        step(2);
        chk(nwr == BW && boot_done, "R6", "restarted dma complete", nwr, BW);

        // Sticky run after completion (R10)
        bus_req = 1; host_we = 1; host_addr = 14'd0;
        step(5);
        bus_req = 0; host_we = 0;
        step(2);
        chk(core_run && boot_done, "R10", "run stays high", {core_run, boot_done}, 3);
        finish_run();
    end
endmodule